// File: doc/BRIEF.md
# Stack-to-Register Translator with Bookmarks

This block sits at the front of a core that executes a stack-machine instruction stream on a register-based backend. Each decoded stack instruction is mapped onto physical registers. Stack slots live in a small table of register numbers with a depth pointer. Registers come from a free pool that always hands out the lowest-numbered free register. Every instruction that produces work leaves the block as one three-address micro-op on a valid/ready handshake.

A function can reserve a fixed number of bookmark registers on entry. A bookmark is a logical index that a mapping table turns into a physical register number. Naming a bookmark lets the code keep a computed value in a register and use it again as a second operand without pushing it from memory. The reservation is released on return. Overflow of the stack window or an empty pool raises a spill request and stalls. The environment then spills the oldest stack slot and acknowledges, which returns that slot's register to the pool.

Top module: `stack_reg_xlat`

## Requirements
- R1: After reset no micro-op is valid, no function frame is active, the stack is empty, every register is free, and with no instruction offered `in_ready` is 1 and `spill_req` is 0.
- R2: Instruction codes on `in_op` are 0 push, 1 pop, 2 alu, 3 bmk, 4 alu-with-bookmark, 5 enter, 6 return, 7 reserved. Micro-op kinds on `uop_kind` are 0 load, 1 move, 2 alu, 3 return. A push takes the lowest-numbered free register as the new top of stack. It emits a load micro-op with that register as destination and `in_imm` copied to `uop_imm`.
- R3: A plain alu op emits an alu micro-op. Source 1 is the register of the second stack entry, source 2 is the top register, the destination is the lowest free register, and `uop_fn` equals `in_fn`. Both source registers return to the pool, and the stack depth drops by one.
- R4: Enter with count K (`in_idx`) reserves the K lowest-numbered free registers in one step as bookmarks 0..K-1, in ascending order, and emits no micro-op.
- R5: Bmk N emits a move micro-op from the top register to the register of bookmark N. The stack is unchanged.
- R6: Alu-with-bookmark N emits an alu micro-op. Source 1 is the top register, source 2 is the register of bookmark N, and the destination is the lowest free register. That destination becomes the new top, the old top register is freed, and the depth is unchanged.
- R7: A bookmark index at or above the active function's count sets `illegal` high for one cycle after acceptance. It emits no micro-op and changes no state.
- R8: The following are also flagged as in R7: pop with an empty stack, alu with fewer than two entries, bmk or alu-with-bookmark with an empty stack, enter while a frame is active or with a count above the maximum, return with no frame, and code 7.
- R9: Return emits a return micro-op and releases all bookmark registers of the frame in the same cycle, so the next push can reuse them.
- R10: A push with the stack full, or any allocation with too few free registers, raises `spill_req` and holds `in_ready` low. A `spill_ack` pulse removes the oldest stack entry and frees its register, after which the instruction proceeds.
- R11: While `uop_valid` is high and `uop_ready` is low, all micro-op outputs stay stable and no instruction is accepted.
- R12: Pop frees the top register and emits no micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_op | input | 3 | Instruction code |
| in_fn | input | 2 | ALU function |
| in_idx | input | BW | Bookmark index or enter count |
| in_imm | input | IMM_W | Push operand |
| spill_ack | input | 1 | Oldest stack entry has been spilled |
| spill_req | output | 1 | Stall for lack of a slot or register |
| illegal | output | 1 | One-cycle illegal-instruction flag |
| uop_valid | output | 1 | Micro-op valid |
| uop_ready | input | 1 | Backend takes the micro-op |
| uop_kind | output | 2 | Micro-op kind |
| uop_fn | output | 2 | ALU function |
| uop_src1 | output | RW | First source register |
| uop_src2 | output | RW | Second source register |
| uop_dst | output | RW | Destination register |
| uop_imm | output | IMM_W | Immediate |

## Verification
The bench builds the block with 8 physical registers, a 6-entry stack window and at most 4 bookmarks. This small pool makes both stall causes reachable in a few instructions. Six pushes fill the window. A 4-bookmark frame plus four pushes empties the pool while the window still has room. With so few registers, reuse after frees and after return shows up directly in the destination numbers.

// File: rtl/stack_reg_xlat.sv
module stack_reg_xlat #(
  parameter int NPHYS = 32,
  parameter int DEPTH = 16,
  parameter int NBMK  = 8,
  parameter int IMM_W = 16,
  localparam int RW  = $clog2(NPHYS),
  localparam int SPW = $clog2(DEPTH + 1),
  localparam int BW  = $clog2(NBMK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [1:0]       in_fn,
  input  logic [BW-1:0]    in_idx,
  input  logic [IMM_W-1:0] in_imm,
  input  logic             spill_ack,
  output logic             spill_req,
  output logic             illegal,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic [1:0]       uop_kind,
  output logic [1:0]       uop_fn,
  output logic [RW-1:0]    uop_src1,
  output logic [RW-1:0]    uop_src2,
  output logic [RW-1:0]    uop_dst,
  output logic [IMM_W-1:0] uop_imm
);
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_ALU = 3'd2, OP_BMK = 3'd3,
                         OP_ABMK = 3'd4, OP_ENTER = 3'd5, OP_RET = 3'd6;
  localparam logic [1:0] K_LOAD = 2'd0, K_MOV = 2'd1, K_ALU = 2'd2, K_RET = 2'd3;
  localparam int SLOTS = 1 << SPW;
  localparam int BSLOTS = 1 << BW;

  logic [RW-1:0]    stk [SLOTS];
  logic [RW-1:0]    bm  [BSLOTS];
  logic [SPW-1:0]   sp_q;
  logic [BW-1:0]    bcnt_q;
  logic             active_q;
  logic [NPHYS-1:0] free_q;

  int free_cnt;
  assign free_cnt = $countones(free_q);

  logic [SPW-1:0] sp_m1, sp_m2;
  logic [RW-1:0]  tos, nos, alloc;
  assign sp_m1 = sp_q - SPW'(1);
  assign sp_m2 = sp_q - SPW'(2);
  assign tos   = stk[sp_m1];
  assign nos   = stk[sp_m2];

  always_comb begin
    alloc = '0;
    for (int i = NPHYS - 1; i >= 0; i--)
      if (free_q[i]) alloc = RW'(i);
  end

  logic [RW-1:0]    ent_bm [BSLOTS];
  logic [NPHYS-1:0] ent_mask;
  always_comb begin
    int k;
    k = 0;
    ent_mask = '0;
    for (int j = 0; j < BSLOTS; j++) ent_bm[j] = bm[j];
    for (int i = 0; i < NPHYS; i++)
      if (free_q[i] && k < int'(in_idx) && k < NBMK) begin
        ent_bm[k] = RW'(i);
        ent_mask[i] = 1'b1;
        k++;
      end
  end

  logic bad, short, emits;
  logic bidx_bad;
  assign bidx_bad = (in_idx >= bcnt_q);
  always_comb begin
    bad = 1'b0;
    short = 1'b0;
    emits = 1'b0;
    case (in_op)
      OP_PUSH:  begin short = (sp_q == SPW'(DEPTH)) || free_cnt == 0; emits = 1'b1; end
      OP_POP:   bad = (sp_q == '0);
      OP_ALU:   begin bad = (sp_q < SPW'(2)); short = free_cnt == 0; emits = 1'b1; end
      OP_BMK:   begin bad = (sp_q == '0) || bidx_bad; emits = 1'b1; end
      OP_ABMK:  begin bad = (sp_q == '0) || bidx_bad; short = free_cnt == 0; emits = 1'b1; end
      OP_ENTER: begin bad = active_q || int'(in_idx) > NBMK; short = free_cnt < int'(in_idx); end
      OP_RET:   begin bad = !active_q; emits = 1'b1; end
      default:  bad = 1'b1;
    endcase
  end

  logic stall, acc, go;
  assign stall     = short && !bad;
  assign in_ready  = !spill_ack && (!uop_valid || uop_ready) && !stall;
  assign spill_req = in_valid && stall;
  assign acc       = in_valid && in_ready;
  assign go        = acc && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q      <= '0;
      bcnt_q    <= '0;
      active_q  <= 1'b0;
      free_q    <= '1;
      illegal   <= 1'b0;
      uop_valid <= 1'b0;
      uop_kind  <= '0;
      uop_fn    <= '0;
      uop_src1  <= '0;
      uop_src2  <= '0;
      uop_dst   <= '0;
      uop_imm   <= '0;
      for (int i = 0; i < SLOTS; i++) stk[i] <= '0;
      for (int j = 0; j < BSLOTS; j++) bm[j] <= '0;
    end else begin
      illegal <= acc && bad;
      if (spill_ack && sp_q != '0) begin
        for (int i = 0; i < SLOTS - 1; i++) stk[i] <= stk[i+1];
        free_q[stk[0]] <= 1'b1;
        sp_q <= sp_m1;
      end
      if (go) begin
        case (in_op)
          OP_PUSH: begin
            stk[sp_q] <= alloc;
            free_q[alloc] <= 1'b0;
            sp_q <= sp_q + SPW'(1);
          end
          OP_POP: begin
            free_q[tos] <= 1'b1;
            sp_q <= sp_m1;
          end
          OP_ALU: begin
            free_q[tos] <= 1'b1;
            free_q[nos] <= 1'b1;
            free_q[alloc] <= 1'b0;
            stk[sp_m2] <= alloc;
            sp_q <= sp_m1;
          end
          OP_ABMK: begin
            free_q[tos] <= 1'b1;
            free_q[alloc] <= 1'b0;
            stk[sp_m1] <= alloc;
          end
          OP_ENTER: begin
            free_q <= free_q & ~ent_mask;
            for (int j = 0; j < BSLOTS; j++) bm[j] <= ent_bm[j];
            bcnt_q <= in_idx;
            active_q <= 1'b1;
          end
          OP_RET: begin
            for (int j = 0; j < BSLOTS; j++)
              if (j < int'(bcnt_q)) free_q[bm[j]] <= 1'b1;
            bcnt_q <= '0;
            active_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (go && emits) begin
        uop_valid <= 1'b1;
        uop_fn    <= in_fn;
        uop_imm   <= '0;
        uop_src1  <= '0;
        uop_src2  <= '0;
        uop_dst   <= '0;
        case (in_op)
          OP_PUSH: begin uop_kind <= K_LOAD; uop_dst <= alloc; uop_imm <= in_imm; end
          OP_ALU:  begin uop_kind <= K_ALU; uop_src1 <= nos; uop_src2 <= tos; uop_dst <= alloc; end
          OP_BMK:  begin uop_kind <= K_MOV; uop_src1 <= tos; uop_dst <= bm[in_idx]; end
          OP_ABMK: begin uop_kind <= K_ALU; uop_src1 <= tos; uop_src2 <= bm[in_idx]; uop_dst <= alloc; end
          default: uop_kind <= K_RET;
        endcase
      end else if (uop_ready) begin
        uop_valid <= 1'b0;
      end
    end
  end

  a_r11_uop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind) && $stable(uop_fn) &&
      $stable(uop_src1) && $stable(uop_src2) && $stable(uop_dst) && $stable(uop_imm));

  a_r10_spill_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req |-> !in_ready);

  a_r6_alu_dst_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_kind == K_ALU |-> uop_dst != uop_src1 && uop_dst != uop_src2);

  a_r7_illegal_no_uop: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bad |=> illegal && !uop_valid);

  a_r9_ret_release: assert property (@(posedge clk) disable iff (!rst_n)
    go && in_op == OP_RET && !spill_ack |=> free_cnt == $past(free_cnt) + $past(int'(bcnt_q)));
endmodule

// File: tb/stack_reg_xlat_tb.sv
module stack_reg_xlat_tb;
  localparam int NPHYS = 8, DEPTH = 6, NBMK = 4, IMM_W = 16;
  localparam int RW = $clog2(NPHYS), BW = $clog2(NBMK + 1);
  localparam int PUSH = 0, POP = 1, ALU = 2, BMK = 3, ABMK = 4, ENTER = 5, RET = 6;
  localparam int KLOAD = 0, KMOV = 1, KALU = 2, KRET = 3;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, spill_ack = 0, spill_req, illegal;
  logic [2:0] in_op = 0;
  logic [1:0] in_fn = 0;
  logic [BW-1:0] in_idx = 0;
  logic [IMM_W-1:0] in_imm = 0;
  logic uop_valid, uop_ready = 1;
  logic [1:0] uop_kind, uop_fn;
  logic [RW-1:0] uop_src1, uop_src2, uop_dst;
  logic [IMM_W-1:0] uop_imm;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  stack_reg_xlat #(.NPHYS(NPHYS), .DEPTH(DEPTH), .NBMK(NBMK), .IMM_W(IMM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_fn(in_fn), .in_idx(in_idx), .in_imm(in_imm), .spill_ack(spill_ack),
    .spill_req(spill_req), .illegal(illegal), .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_kind(uop_kind), .uop_fn(uop_fn), .uop_src1(uop_src1), .uop_src2(uop_src2),
    .uop_dst(uop_dst), .uop_imm(uop_imm));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; in_valid = 0; spill_ack = 0; uop_ready = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(int op, int fn, int idx, int imm);
    @(negedge clk);
    in_valid = 1; in_op = 3'(op); in_fn = 2'(fn); in_idx = BW'(idx); in_imm = IMM_W'(imm);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic uop_is(string req, int kind, int s1, int s2, int d);
    chk({req, " valid"}, int'(uop_valid), 1);
    chk({req, " kind"}, int'(uop_kind), kind);
    chk({req, " src1"}, int'(uop_src1), s1);
    chk({req, " src2"}, int'(uop_src2), s2);
    chk({req, " dst"}, int'(uop_dst), d);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 uop_valid", int'(uop_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 spill_req", int'(spill_req), 0);
    chk("R1 illegal", int'(illegal), 0);
  endtask

  task automatic t_push_alu();
    do_reset();
    send(PUSH, 0, 0, 5);  uop_is("R2 push0", KLOAD, 0, 0, 0);
    chk("R2 imm", int'(uop_imm), 5);
    send(PUSH, 0, 0, 7);  uop_is("R2 push1", KLOAD, 0, 0, 1);
    send(ALU, 2, 0, 0);   uop_is("R3 alu", KALU, 0, 1, 2);
    chk("R3 fn", int'(uop_fn), 2);
    send(PUSH, 0, 0, 9);  uop_is("R3 reuse", KLOAD, 0, 0, 0);
    send(ALU, 1, 0, 0);   uop_is("R3 alu2", KALU, 2, 0, 1);
  endtask

  task automatic t_bookmarks();
    do_reset();
    send(ENTER, 0, 2, 0); chk("R4 enter no uop", int'(uop_valid), 0);
    send(PUSH, 0, 0, 3);  uop_is("R4 push after enter", KLOAD, 0, 0, 2);
    send(BMK, 0, 1, 0);   uop_is("R5 bmk", KMOV, 2, 0, 1);
    send(PUSH, 0, 0, 4);  uop_is("R5 stack kept", KLOAD, 0, 0, 3);
    send(ABMK, 0, 1, 0);  uop_is("R6 alu_bmk", KALU, 3, 1, 4);
    send(ALU, 0, 0, 0);   uop_is("R6 depth kept", KALU, 2, 4, 3);
    send(ABMK, 1, 0, 0);  uop_is("R6 alu_bmk0", KALU, 3, 0, 2);
    send(RET, 0, 0, 0);   chk("R9 ret kind", int'(uop_kind), KRET);
    chk("R9 ret valid", int'(uop_valid), 1);
    send(PUSH, 0, 0, 1);  uop_is("R9 freed reg0", KLOAD, 0, 0, 0);
    send(PUSH, 0, 0, 1);  uop_is("R9 freed reg1", KLOAD, 0, 0, 1);
  endtask

  task automatic t_illegal();
    do_reset();
    send(ENTER, 0, 1, 0);
    send(PUSH, 0, 0, 0);  uop_is("R7 setup", KLOAD, 0, 0, 1);
    send(BMK, 0, 1, 0);
    chk("R7 idx=count flag", int'(illegal), 1);
    chk("R7 idx=count no uop", int'(uop_valid), 0);
    send(ABMK, 0, 2, 0);
    chk("R7 abmk flag", int'(illegal), 1);
    chk("R7 abmk no uop", int'(uop_valid), 0);
    send(ENTER, 0, 1, 0); chk("R8 nested enter", int'(illegal), 1);
    send(BMK, 0, 0, 0);   uop_is("R7 state unchanged", KMOV, 1, 0, 0);
    chk("R7 legal no flag", int'(illegal), 0);
    send(RET, 0, 0, 0);   chk("R8 ret ok", int'(illegal), 0);
    send(RET, 0, 0, 0);   chk("R8 ret no frame", int'(illegal), 1);
    send(7, 0, 0, 0);     chk("R8 code 7", int'(illegal), 1);
    send(POP, 0, 0, 0);   chk("R12 pop legal", int'(illegal), 0);
    send(POP, 0, 0, 0);   chk("R8 pop empty", int'(illegal), 1);
    send(ALU, 0, 0, 0);   chk("R8 alu underflow", int'(illegal), 1);
    send(ENTER, 0, 5, 0); chk("R8 count too big", int'(illegal), 1);
  endtask

  task automatic spill_once(string req, int exp_dst);
    @(negedge clk);
    in_valid = 1; in_op = 3'(PUSH); in_idx = 0; in_imm = 0;
    #1;
    chk({req, " spill_req"}, int'(spill_req), 1);
    chk({req, " in_ready"}, int'(in_ready), 0);
    @(negedge clk); spill_ack = 1;
    @(negedge clk); spill_ack = 0;
    @(negedge clk); in_valid = 0;
    uop_is({req, " after ack"}, KLOAD, 0, 0, exp_dst);
  endtask

  task automatic t_spill();
    do_reset();
    for (int i = 0; i < DEPTH; i++) send(PUSH, 0, 0, i);
    chk("R10 last push dst", int'(uop_dst), 5);
    spill_once("R10 full", 0);
    do_reset();
    send(ENTER, 0, 4, 0);
    for (int i = 0; i < 4; i++) send(PUSH, 0, 0, i);
    chk("R10 pool last dst", int'(uop_dst), 7);
    spill_once("R10 empty pool", 4);
  endtask

  task automatic t_hold();
    do_reset();
    uop_ready = 0;
    send(PUSH, 0, 0, 11);
    uop_is("R11 first", KLOAD, 0, 0, 0);
    @(negedge clk);
    in_valid = 1; in_op = 3'(PUSH); in_imm = 12;
    #1; chk("R11 blocked", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk("R11 held dst", int'(uop_dst), 0);
    chk("R11 held imm", int'(uop_imm), 11);
    chk("R11 held valid", int'(uop_valid), 1);
    uop_ready = 1;
    #1; chk("R11 release", int'(in_ready), 1);
    @(negedge clk); in_valid = 0;
    chk("R11 next dst", int'(uop_dst), 1);
    chk("R11 next imm", int'(uop_imm), 12);
  endtask

  task automatic t_pop();
    do_reset();
    send(PUSH, 0, 0, 0);
    send(PUSH, 0, 0, 0);
    send(POP, 0, 0, 0);
    chk("R12 no uop", int'(uop_valid), 0);
    send(PUSH, 0, 0, 0);
    uop_is("R12 reg freed", KLOAD, 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_push_alu();
    t_bookmarks();
    t_illegal();
    t_spill();
    t_hold();
    t_pop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule